// File: doc/BRIEF.md
# Audio DMA Bridge Channel

This block moves audio samples between a memory buffer and an audio serial port, one playback direction and one record direction. Playback fetches words from memory at ascending addresses and offers them on an outgoing stream; record accepts words from an incoming stream and stores them at ascending addresses. Both directions share a single request/grant memory port, on which a pending record write takes precedence over a pending playback read.

Software programs each direction through a small register file. It sets a start address and a byte count, then sets the enable bit in the shared control register. A sticky status bit records the moment half the programmed bytes have moved, and another records the moment all of them have. The interrupt line is high while any status bit is set. With auto-reload on, a direction that reaches its count reloads its address and count from the registers and keeps going. Software then sees an endless two-half ring buffer until it writes the direction's stop bit.

Top module: `adb_bridge`

## Requirements
- R1: Register offsets are 0x00 playback base, 0x04 record base, 0x08 playback count, 0x0C record count, 0x10 control, 0x14 playback remaining, 0x18 record remaining, 0x1C status. Base and count registers hold their written value with bits 1:0 cleared. Count registers keep only bits 25:0. Every register reads zero after reset.
- R2: Control bit 0 starts playback and bit 16 starts record, when written as 1 while that direction is idle. While the direction is active, the same bit reads 1.
- R3: Playback delivers the words at base, base+4, base+8 … in order on the outgoing stream. A word offered and not accepted stays stable. The remaining count drops by 4 for each accepted word.
- R4: Record stores each accepted incoming word, in arrival order, at base, base+4, base+8 …
- R5: Status bit 0 (playback) and bit 2 (record) set when at least half the programmed bytes have moved. Bit 1 and bit 3 set when all of them have moved. Writing 1 to a status bit clears it. `irq` is high while any status bit is set.
- R6: Control bit 2 (playback) and bit 18 (record) select auto-reload. When the count completes, address and count reload from the registers, the direction stays active and transfers continue.
- R7: Without auto-reload, completing the count leaves the direction idle: its enable bit reads 0, its remaining count reads 0 and its stream stays quiet.
- R8: Writing 1 to control bit 1 (playback) or bit 17 (record) ends that direction at once. Its enable bit and remaining count then read 0 and it makes no further stream or memory activity. Writing 0 to a stop bit, or 0 to an enable bit, changes nothing.
- R9: Stopping one direction leaves the other direction running.
- R10: A start whose programmed count is below 8 bytes is ignored and the direction stays idle.
- R11: When both directions wait on the memory port, the record write is granted first. A request stays asserted until it is granted or its direction is stopped.
- R12: Control bits 9:8 (playback) and 25:24 (record) hold a 2-bit data alignment code: 0 none, 1 four-byte, 2 two-word. They read back as written. Stop bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq | output | 1 | High while any status bit is set |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write (record), 0 = read (playback) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Grant; completes the access in the same cycle |
| mem_rdata | input | 32 | Read data, valid in the grant cycle |
| tx_valid | output | 1 | Playback word offered |
| tx_data | output | 32 | Playback word |
| tx_ready | input | 1 | Serial port accepts the playback word |
| rx_valid | input | 1 | Record word offered by the serial port |
| rx_data | input | 32 | Record word |
| rx_ready | output | 1 | Block accepts the record word |

## Verification
The assertions assume a memory side that returns read data in the same cycle it raises `mem_gnt`, and that never grants an absent request. They also assume stream partners that follow valid/ready without conditions on the opposite side. The bench meets this by computing read data combinationally from `mem_addr`. It raises grant on a fixed two-of-three cycle pattern, or holds it low on purpose, and it raises `tx_ready` only when the scoreboard expects a word. It also presents record words only while its budget lasts, and writes registers only between clock edges. Counts are always multiples of four and at least 8 bytes, except for the one case that tests the rejected short count.

// File: rtl/adb_pkg.sv
package adb_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_GET,
        PH_PUT
    } phase_e;

    localparam int          OFF_W       = 5;
    localparam logic [4:0]  OFF_TX_BASE = 5'h00;
    localparam logic [4:0]  OFF_RX_BASE = 5'h04;
    localparam logic [4:0]  OFF_TX_CNT  = 5'h08;
    localparam logic [4:0]  OFF_RX_CNT  = 5'h0C;
    localparam logic [4:0]  OFF_CTL     = 5'h10;
    localparam logic [4:0]  OFF_TX_LIVE = 5'h14;
    localparam logic [4:0]  OFF_RX_LIVE = 5'h18;
    localparam logic [4:0]  OFF_STAT    = 5'h1C;

    localparam int B_TX_EN   = 0;
    localparam int B_TX_STOP = 1;
    localparam int B_TX_AUTO = 2;
    localparam int B_TX_ALN  = 8;
    localparam int B_RX_EN   = 16;
    localparam int B_RX_STOP = 17;
    localparam int B_RX_AUTO = 18;
    localparam int B_RX_ALN  = 24;

endpackage

// File: rtl/adb_engine.sv
// One transfer direction: obtain a word (GET), deliver it (PUT), count bytes.
module adb_engine
    import adb_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int CW        = 26,
    parameter int MIN_BYTES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          reload_i,
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] count_i,
    input  logic          in_fire_i,
    input  logic [DW-1:0] in_data_i,
    input  logic          out_fire_i,
    output logic          want_in_o,
    output logic          want_out_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic [CW-1:0] live_o,
    output logic          busy_o,
    output logic          half_o,
    output logic          full_o
);

    localparam logic [CW-1:0] STEP  = CW'(DW / 8);
    localparam logic [AW-1:0] ASTEP = AW'(DW / 8);
    localparam logic [CW-1:0] MINC  = CW'(MIN_BYTES);

    typedef struct packed {
        phase_e        ph;
        logic [AW-1:0] addr;
        logic [CW-1:0] rem;
        logic [CW-1:0] tot;
        logic [DW-1:0] word;
    } eng_t;

    eng_t          st_d, st_q;
    logic          load_ok;
    logic [CW-1:0] half_thr;
    logic [CW-1:0] rem_nx;

    always_comb begin
        load_ok  = (count_i >= MINC);
        half_thr = st_q.tot - (st_q.tot >> 1);
        rem_nx   = st_q.rem - STEP;
        st_d     = st_q;
        half_o   = 1'b0;
        full_o   = 1'b0;

        unique case (st_q.ph)
            PH_IDLE: begin
                if (start_i && load_ok) begin
                    st_d.ph   = PH_GET;
                    st_d.addr = base_i;
                    st_d.rem  = count_i;
                    st_d.tot  = count_i;
                end
            end
            PH_GET: begin
                if (in_fire_i) begin
                    st_d.word = in_data_i;
                    st_d.ph   = PH_PUT;
                end
            end
            PH_PUT: begin
                if (out_fire_i) begin
                    st_d.rem  = rem_nx;
                    st_d.addr = st_q.addr + ASTEP;
                    st_d.ph   = PH_GET;
                    half_o    = (st_q.rem > half_thr) && (rem_nx <= half_thr);
                    if (rem_nx == '0) begin
                        full_o = 1'b1;
                        if (reload_i && load_ok) begin
                            st_d.addr = base_i;
                            st_d.rem  = count_i;
                            st_d.tot  = count_i;
                        end else begin
                            st_d.ph  = PH_IDLE;
                            st_d.rem = '0;
                        end
                    end
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase

        if (stop_i) begin
            st_d.ph  = PH_IDLE;
            st_d.rem = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign want_in_o  = (st_q.ph == PH_GET);
    assign want_out_o = (st_q.ph == PH_PUT);
    assign addr_o     = st_q.addr;
    assign data_o     = st_q.word;
    assign live_o     = st_q.rem;
    assign busy_o     = (st_q.ph != PH_IDLE);

endmodule

// File: rtl/adb_arb.sv
// Shares the memory port; a pending record write wins over a playback read.
module adb_arb #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          tx_req_i,
    input  logic [AW-1:0] tx_addr_i,
    input  logic          rx_req_i,
    input  logic [AW-1:0] rx_addr_i,
    input  logic [DW-1:0] rx_data_i,
    input  logic          mem_gnt_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic          tx_gnt_o,
    output logic          rx_gnt_o
);

    always_comb begin
        mem_req_o   = tx_req_i || rx_req_i;
        mem_we_o    = rx_req_i;
        mem_addr_o  = rx_req_i ? rx_addr_i : tx_addr_i;
        mem_wdata_o = rx_data_i;
        rx_gnt_o    = rx_req_i && mem_gnt_i;
        tx_gnt_o    = tx_req_i && !rx_req_i && mem_gnt_i;
    end

endmodule

// File: rtl/adb_bridge.sv
module adb_bridge
    import adb_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int CW        = 26,
    parameter int MIN_BYTES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [OFF_W-1:0] reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_gnt,
    input  logic [DW-1:0]    mem_rdata,
    output logic             tx_valid,
    output logic [DW-1:0]    tx_data,
    input  logic             tx_ready,
    input  logic             rx_valid,
    input  logic [DW-1:0]    rx_data,
    output logic             rx_ready
);

    localparam int RW = 32;

    typedef struct packed {
        logic [AW-1:0] tx_base;
        logic [AW-1:0] rx_base;
        logic [CW-1:0] tx_cnt;
        logic [CW-1:0] rx_cnt;
        logic          tx_auto;
        logic          rx_auto;
        logic [1:0]    tx_aln;
        logic [1:0]    rx_aln;
        logic [3:0]    stat;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic          wr_ctl;
    logic          tx_start, tx_stop, rx_start, rx_stop;
    logic          tx_req, rx_req, tx_gnt, rx_gnt;
    logic [AW-1:0] tx_addr, rx_addr;
    logic [DW-1:0] rx_word;
    logic [CW-1:0] tx_live, rx_live;
    logic          tx_busy, rx_busy;
    logic          tx_half, tx_full, rx_half, rx_full;

    // control decode: a stop in the same write overrides a start
    always_comb begin
        wr_ctl   = reg_wr && (reg_addr == OFF_CTL);
        tx_stop  = wr_ctl && reg_wdata[B_TX_STOP];
        rx_stop  = wr_ctl && reg_wdata[B_RX_STOP];
        tx_start = wr_ctl && reg_wdata[B_TX_EN] && !reg_wdata[B_TX_STOP];
        rx_start = wr_ctl && reg_wdata[B_RX_EN] && !reg_wdata[B_RX_STOP];
    end

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            unique case (reg_addr)
                OFF_TX_BASE: cfg_d.tx_base = {reg_wdata[AW-1:2], 2'b00};
                OFF_RX_BASE: cfg_d.rx_base = {reg_wdata[AW-1:2], 2'b00};
                OFF_TX_CNT:  cfg_d.tx_cnt  = {reg_wdata[CW-1:2], 2'b00};
                OFF_RX_CNT:  cfg_d.rx_cnt  = {reg_wdata[CW-1:2], 2'b00};
                OFF_CTL: begin
                    cfg_d.tx_auto = reg_wdata[B_TX_AUTO];
                    cfg_d.rx_auto = reg_wdata[B_RX_AUTO];
                    cfg_d.tx_aln  = reg_wdata[B_TX_ALN +: 2];
                    cfg_d.rx_aln  = reg_wdata[B_RX_ALN +: 2];
                end
                OFF_STAT:    cfg_d.stat = cfg_q.stat & ~reg_wdata[3:0];
                default: ;
            endcase
        end
        // a new event wins over a clear in the same cycle
        cfg_d.stat = cfg_d.stat | {rx_full, rx_half, tx_full, tx_half};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFF_TX_BASE: reg_rdata = RW'(cfg_q.tx_base);
            OFF_RX_BASE: reg_rdata = RW'(cfg_q.rx_base);
            OFF_TX_CNT:  reg_rdata = RW'(cfg_q.tx_cnt);
            OFF_RX_CNT:  reg_rdata = RW'(cfg_q.rx_cnt);
            OFF_CTL: begin
                reg_rdata = '0;
                reg_rdata[B_TX_EN]       = tx_busy;
                reg_rdata[B_TX_AUTO]     = cfg_q.tx_auto;
                reg_rdata[B_TX_ALN +: 2] = cfg_q.tx_aln;
                reg_rdata[B_RX_EN]       = rx_busy;
                reg_rdata[B_RX_AUTO]     = cfg_q.rx_auto;
                reg_rdata[B_RX_ALN +: 2] = cfg_q.rx_aln;
            end
            OFF_TX_LIVE: reg_rdata = RW'(tx_live);
            OFF_RX_LIVE: reg_rdata = RW'(rx_live);
            OFF_STAT:    reg_rdata = RW'(cfg_q.stat);
            default:     reg_rdata = '0;
        endcase
    end

    assign irq = |cfg_q.stat;

    // playback: GET from memory, PUT to the outgoing stream
    adb_engine #(.AW(AW), .DW(DW), .CW(CW), .MIN_BYTES(MIN_BYTES)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (tx_start),
        .stop_i     (tx_stop),
        .reload_i   (cfg_q.tx_auto),
        .base_i     (cfg_q.tx_base),
        .count_i    (cfg_q.tx_cnt),
        .in_fire_i  (tx_gnt),
        .in_data_i  (mem_rdata),
        .out_fire_i (tx_valid && tx_ready),
        .want_in_o  (tx_req),
        .want_out_o (tx_valid),
        .addr_o     (tx_addr),
        .data_o     (tx_data),
        .live_o     (tx_live),
        .busy_o     (tx_busy),
        .half_o     (tx_half),
        .full_o     (tx_full)
    );

    // record: GET from the incoming stream, PUT to memory
    adb_engine #(.AW(AW), .DW(DW), .CW(CW), .MIN_BYTES(MIN_BYTES)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (rx_start),
        .stop_i     (rx_stop),
        .reload_i   (cfg_q.rx_auto),
        .base_i     (cfg_q.rx_base),
        .count_i    (cfg_q.rx_cnt),
        .in_fire_i  (rx_valid && rx_ready),
        .in_data_i  (rx_data),
        .out_fire_i (rx_gnt),
        .want_in_o  (rx_ready),
        .want_out_o (rx_req),
        .addr_o     (rx_addr),
        .data_o     (rx_word),
        .live_o     (rx_live),
        .busy_o     (rx_busy),
        .half_o     (rx_half),
        .full_o     (rx_full)
    );

    adb_arb #(.AW(AW), .DW(DW)) u_arb (
        .tx_req_i    (tx_req),
        .tx_addr_i   (tx_addr),
        .rx_req_i    (rx_req),
        .rx_addr_i   (rx_addr),
        .rx_data_i   (rx_word),
        .mem_gnt_i   (mem_gnt),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .tx_gnt_o    (tx_gnt),
        .rx_gnt_o    (rx_gnt)
    );

endmodule

// File: rtl/adb_chk.sv
module adb_chk #(
    parameter int DW        = 32,
    parameter int CW        = 26,
    parameter int MIN_BYTES = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_req,
    input logic          rx_req,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic          tx_start,
    input logic          tx_stop,
    input logic          rx_stop,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [DW-1:0] tx_data,
    input logic [CW-1:0] tx_live,
    input logic [CW-1:0] tx_cnt,
    input logic          tx_busy,
    input logic          rx_busy,
    input logic          tx_full,
    input logic          rx_full,
    input logic          tx_auto,
    input logic [3:0]    stat
);

    // R11
    rx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && rx_req && mem_gnt && !tx_stop && !rx_stop) |=> (tx_req && !rx_req));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !tx_stop && !rx_stop) |=> mem_req);

    // R3
    tx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !tx_stop) |=> (tx_valid && $stable(tx_data)));

    // R5
    tx_full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |=> stat[1]);

    // R5
    rx_full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |=> stat[3]);

    // R7
    tx_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && !tx_auto && !tx_stop) |=> !tx_busy);

    // R8
    tx_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stop |=> (!tx_valid && !tx_busy && tx_live == '0));

    // R9
    rx_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_stop && !rx_stop && rx_busy && !rx_full) |=> rx_busy);

    // R10
    short_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && !tx_busy && tx_cnt < CW'(MIN_BYTES)) |=> !tx_busy);

endmodule

bind adb_bridge adb_chk #(.DW(DW), .CW(CW), .MIN_BYTES(MIN_BYTES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_req   (tx_req),
    .rx_req   (rx_req),
    .mem_req  (mem_req),
    .mem_gnt  (mem_gnt),
    .tx_start (tx_start),
    .tx_stop  (tx_stop),
    .rx_stop  (rx_stop),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_live  (tx_live),
    .tx_cnt   (cfg_q.tx_cnt),
    .tx_busy  (tx_busy),
    .rx_busy  (rx_busy),
    .tx_full  (tx_full),
    .rx_full  (rx_full),
    .tx_auto  (cfg_q.tx_auto),
    .stat     (cfg_q.stat)
);

// File: tb/adb_bridge_tb.sv
module adb_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_gnt = 1'b0;
    logic        tx_valid;
    logic [31:0] tx_data;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_data = '0;
    logic        rx_ready;

    always #2 clk = ~clk;

    adb_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
    );

    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;
    logic [31:0] txq[$];
    logic [63:0] rxq[$];
    bit          tx_en = 1'b0;
    bit          gnt_en = 1'b0;
    int          rx_budget = 0;
    logic [31:0] rx_word = 32'hCAFE0000;
    logic [31:0] rx_exp_addr = '0;

    function automatic logic [31:0] mval(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    assign mem_rdata = mval(mem_addr);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // driver of port-side stimulus and scoreboard monitor, all at the falling edge
    always @(negedge clk) begin
        logic        gn, rdy, vld;
        logic [63:0] e;
        logic [31:0] t;
        cyc++;
        gn  = gnt_en && (cyc % 3 != 1);
        rdy = tx_en && (txq.size() > 0);
        vld = (rx_budget > 0);
        if (mem_req && mem_we && gn) begin
            if (rxq.size() == 0) begin
                chk(1'b0, "R4 unexpected record write", mem_addr, 32'h0);
            end else begin
                e = rxq.pop_front();
                chk(mem_addr == e[63:32], "R4 record address", mem_addr, e[63:32]);
                chk(mem_wdata == e[31:0], "R4 record data", mem_wdata, e[31:0]);
            end
        end
        if (tx_valid && rdy) begin
            t = txq.pop_front();
            chk(tx_data == t, "R3 playback word", tx_data, t);
        end
        rx_data <= rx_word;
        if (vld && rx_ready) begin
            rxq.push_back({rx_exp_addr, rx_word});
            rx_exp_addr = rx_exp_addr + 32'd4;
            rx_budget   = rx_budget - 1;
            rx_word     = rx_word + 32'd1;
        end
        mem_gnt  <= gn;
        tx_ready <= rdy;
        rx_valid <= vld;
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (all requirements): actual=%0d expected=<100000 cycles", cyc);
            finish_run();
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ctl_clear(input logic [31:0] mask, input int limit);
        logic [31:0] v;
        for (int i = 0; i < limit; i++) begin
            rd(5'h10, v);
            if ((v & mask) == 0) return;
        end
    endtask

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // reset state
        for (int i = 0; i < 8; i++) begin
            rd(5'(i * 4), v);
            chk(v == 32'h0, "R1 reset register value", v, 32'h0);
        end
        chk(irq == 1'b0, "R5 irq low after reset", 32'(irq), 32'h0);
        chk(!tx_valid && !mem_req && !rx_ready, "R1 ports quiet after reset",
            {29'h0, tx_valid, mem_req, rx_ready}, 32'h0);

        // R1 register storage and masking
        wr(5'h00, 32'h0000_1003); rd(5'h00, v); chk(v == 32'h1000, "R1 playback base", v, 32'h1000);
        wr(5'h04, 32'h0000_2000); rd(5'h04, v); chk(v == 32'h2000, "R1 record base", v, 32'h2000);
        wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, v); chk(v == 32'h03FF_FFFC, "R1 count width", v, 32'h03FF_FFFC);
        wr(5'h0C, 32'h0000_0013); rd(5'h0C, v); chk(v == 32'h10, "R1 count low bits", v, 32'h10);

        // R12 alignment fields, stop bits not stored
        wr(5'h10, 32'h0200_0100); rd(5'h10, v); chk(v == 32'h0200_0100, "R12 alignment readback", v, 32'h0200_0100);

        // R10 count below minimum
        wr(5'h08, 32'h4);
        wr(5'h10, 32'h1);
        idle(6);
        rd(5'h10, v); chk(v[0] == 1'b0, "R10 short count start ignored", v, 32'h0);
        chk(!tx_valid && !mem_req, "R10 no activity", {30'h0, tx_valid, mem_req}, 32'h0);

        // R3 R5 R8 controlled playback
        gnt_en = 1'b1; tx_en = 1'b1;
        wr(5'h00, 32'h1000);
        wr(5'h08, 32'd16);
        wr(5'h10, 32'h1);
        idle(10);
        rd(5'h10, v); chk(v == 32'h1, "R2 enable reads active", v, 32'h1);
        chk(tx_valid == 1'b1, "R3 first word offered", 32'(tx_valid), 32'h1);
        chk(tx_data == mval(32'h1000), "R3 first word held", tx_data, mval(32'h1000));
        rd(5'h14, v); chk(v == 32'd16, "R3 remaining before transfer", v, 32'd16);
        txq.push_back(mval(32'h1000));
        idle(10);
        rd(5'h14, v); chk(v == 32'd12, "R3 remaining after one word", v, 32'd12);
        rd(5'h1C, v); chk(v == 32'h0, "R5 no half event yet", v, 32'h0);
        txq.push_back(mval(32'h1004));
        idle(10);
        rd(5'h1C, v); chk(v == 32'h1, "R5 half event", v, 32'h1);
        chk(irq == 1'b1, "R5 irq follows status", 32'(irq), 32'h1);
        wr(5'h10, 32'h0);
        rd(5'h10, v); chk(v[0] == 1'b1, "R8 zero write has no effect", v, 32'h1);
        wr(5'h10, 32'h2);
        rd(5'h10, v); chk(v[0] == 1'b0, "R8 stop clears enable", v, 32'h0);
        rd(5'h14, v); chk(v == 32'h0, "R8 remaining zero after stop", v, 32'h0);
        idle(10);
        chk(!tx_valid && !mem_req, "R8 no activity after stop", {30'h0, tx_valid, mem_req}, 32'h0);
        wr(5'h1C, 32'h1);
        rd(5'h1C, v); chk(v == 32'h0, "R5 write-one clear", v, 32'h0);
        chk(irq == 1'b0, "R5 irq drops", 32'(irq), 32'h0);

        // R7 single pass without reload
        for (int i = 0; i < 4; i++) txq.push_back(mval(32'h1000 + 32'(i * 4)));
        wr(5'h10, 32'h1);
        wait_ctl_clear(32'h1, 300);
        chk(txq.size() == 0, "R3 all words delivered", 32'(txq.size()), 32'h0);
        rd(5'h1C, v); chk(v == 32'h3, "R5 half and full events", v, 32'h3);
        rd(5'h14, v); chk(v == 32'h0, "R7 remaining zero at end", v, 32'h0);
        idle(10);
        chk(!tx_valid && !mem_req, "R7 idle after completion", {30'h0, tx_valid, mem_req}, 32'h0);
        wr(5'h1C, 32'hF);

        // R11 record write wins a contested port
        gnt_en = 1'b0;
        wr(5'h08, 32'd8);
        wr(5'h0C, 32'd8);
        rx_exp_addr = 32'h2000;
        rx_budget = 1;
        wr(5'h10, 32'h0001_0001);
        idle(10);
        chk(mem_req && mem_we, "R11 record granted first", {30'h0, mem_req, mem_we}, 32'h3);
        chk(mem_addr == 32'h2000, "R11 record address presented", mem_addr, 32'h2000);
        txq.push_back(mval(32'h1000));
        txq.push_back(mval(32'h1004));
        rx_budget = 1;
        gnt_en = 1'b1;
        wait_ctl_clear(32'h0001_0001, 300);
        chk(txq.size() == 0 && rxq.size() == 0, "R4 both directions drained",
            32'(txq.size() + rxq.size()), 32'h0);
        rd(5'h1C, v); chk(v == 32'hF, "R5 all four events", v, 32'hF);
        rd(5'h18, v); chk(v == 32'h0, "R7 record remaining zero", v, 32'h0);
        wr(5'h1C, 32'hF);

        // R6 R9 ring playback with a long record running alongside
        wr(5'h0C, 32'd256);
        rx_exp_addr = 32'h2000;
        rx_budget = 200;
        for (int i = 0; i < 6; i++) txq.push_back(mval(32'h1000 + 32'((i % 2) * 4)));
        wr(5'h10, 32'h0001_0005);
        for (int i = 0; i < 400 && txq.size() != 0; i++) idle(1);
        idle(3);
        rd(5'h10, v); chk(v[0] == 1'b1, "R6 playback still active after reload", v, 32'h1);
        rd(5'h14, v); chk(v == 32'd8, "R6 remaining reloaded", v, 32'd8);
        rd(5'h1C, v); chk(v[1] == 1'b1, "R6 full event on wrap", v, 32'h2);
        wr(5'h10, 32'h0001_0006);
        rd(5'h10, v); chk(v == 32'h0001_0004, "R9 record survives playback stop", v, 32'h0001_0004);
        wait_ctl_clear(32'h0001_0000, 2000);
        chk(rxq.size() == 0, "R4 all record words stored", 32'(rxq.size()), 32'h0);
        rd(5'h1C, v); chk(v[3] == 1'b1, "R5 record full event", v, 32'h8);
        chk(!tx_valid, "R8 playback quiet after stop", 32'(tx_valid), 32'h0);
        rx_budget = 0;
        idle(4);

        finish_run();
    end

endmodule